// File: doc/BRIEF.md
# Scoped Page and Phase Write Dispatcher

This block sits behind an SMBus/PMBus slave front end that has already split each transaction into a command byte, a stream of data bytes and an end marker. It recognises one special block-write command. That command names a page, a phase and a target command code, and then carries the target command's own data bytes. The block turns such a frame into a single register-write strobe. The strobe carries the target code, a phase mask and the data. The page and phase named in the frame apply to that one write only. The persistent page and phase selectors keep their values.

Both selectors in the frame are checked before anything is dispatched. The page must be 00h or FFh, and the two values behave the same. The phase must be FFh (all phases) or equal to this device's stack position. A failed check, or a frame whose byte count is wrong, produces no strobe. Instead it raises a sticky invalid-command flag and pulls the active-low alert output low. The flag stays set until software pulses the clear input. Plain one-byte writes to the page and phase commands load the persistent selectors, which are exposed for the rest of the chip. The scoped write is never stored anywhere: it takes effect at once and leaves no trace other than the strobe.

Top module: `pmb_scoped_write`

## Requirements
- R1: A frame that opens with code 09h, then has the block count NEST_BYTES+3 (5 by default), then the bytes page, phase, target code and data (first data byte first) produces a one-cycle wr_stb in the first cycle after its last byte. With the strobe, wr_cmd is the target code and wr_data holds the data bytes, the first data byte in bits 7:0. This count is one more than a write that names only a page and a command.
- R2: Page values 00h and FFh are both accepted and give identical strobe outputs.
- R3: Phase FFh gives wr_phase_mask of all ones. A phase equal to stack_pos gives a mask with only bit stack_pos set.
- R4: Any other page or phase value gives no strobe. In that case inv_cmd is set in the second cycle after the last byte, and alert_n goes low.
- R5: A block count other than NEST_BYTES+3 gives no strobe. inv_cmd is set in the second cycle after the count byte, and the rest of that frame is ignored.
- R6: inv_cmd stays set until clr_status is high on a clock edge. A new error in the same cycle as a clear wins, and alert_n is always the inverse of inv_cmd.
- R7: A one-byte write with code 00h loads sel_page, and a one-byte write with code 04h loads sel_phase. Each takes effect in the cycle after the byte. A scoped frame, valid or not, leaves both unchanged.
- R8: Frames with any other command code give no strobe, do not touch inv_cmd and change no selector.
- R9: A scoped frame ended by frm_stop before all of its payload bytes arrive gives no strobe and no flag.
- R10: After reset, wr_stb is 0, inv_cmd is 0, alert_n is 1, and sel_page and sel_phase are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_start | input | 1 | Marks the command-code byte of a new frame on frm_byte |
| frm_valid | input | 1 | Marks a data byte on frm_byte |
| frm_byte | input | 8 | Byte from the slave front end |
| frm_stop | input | 1 | End of the current frame |
| stack_pos | input | POS_W | This device's phase position |
| clr_status | input | 1 | Clears the invalid-command flag |
| wr_stb | output | 1 | One-cycle register-write strobe |
| wr_cmd | output | 8 | Target command code, valid with wr_stb |
| wr_phase_mask | output | 2**POS_W | Phases addressed by the write, valid with wr_stb |
| wr_data | output | 8*NEST_BYTES | Target command data, valid with wr_stb |
| inv_cmd | output | 1 | Sticky invalid-command flag |
| alert_n | output | 1 | Active-low alert |
| sel_page | output | 8 | Persistent page selector |
| sel_phase | output | 8 | Persistent phase selector |

## Verification
The assertions assume that stack_pos is a static configuration value, that frm_start and frm_valid are never high in the same cycle, and that two frames are always at least a few cycles apart. They also assume that frm_valid is not paired with frm_stop. The directed stimulus drives one marker per cycle on the falling edge and holds stack_pos at 5 for the whole run. It ends every frame with a stop cycle of its own, so the strobe-shape and mask checks always see a settled position and well-separated frames.

// File: rtl/pmb_sw_pkg.sv
package pmb_sw_pkg;

  // Frame collector states
  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_COUNT = 3'd1,
    PS_BODY  = 3'd2,
    PS_PAGE  = 3'd3,
    PS_PHASE = 3'd4,
    PS_SKIP  = 3'd5
  } pstate_t;

  // Byte positions inside the scoped payload (order matters to the decode)
  localparam int unsigned POS_PAGE  = 0;
  localparam int unsigned POS_PHASE = 1;
  localparam int unsigned POS_CMD   = 2;
  localparam int unsigned POS_DATA  = 3;

endpackage

// File: rtl/pmb_sw_rst_sync.sv
module pmb_sw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pmb_sw_parse.sv
module pmb_sw_parse
  import pmb_sw_pkg::*;
#(
  parameter logic [7:0]  SCOPED_CODE = 8'h09,
  parameter logic [7:0]  PAGE_CODE   = 8'h00,
  parameter logic [7:0]  PHASE_CODE  = 8'h04,
  parameter int unsigned FRAME_LEN   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frm_start,
  input  logic                   frm_valid,
  input  logic [7:0]             frm_byte,
  input  logic                   frm_stop,
  output logic                   done_o,
  output logic                   cnt_err_o,
  output logic                   pg_we_o,
  output logic                   ph_we_o,
  output logic [8*FRAME_LEN-1:0] frame_o
);

  localparam int unsigned       IDX_W    = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [7:0]        EXP_CNT  = 8'(FRAME_LEN);

  pstate_t          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             cerr_q, cerr_d;
  logic             byte_we;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    cerr_d  = 1'b0;
    byte_we = 1'b0;
    pg_we_o = 1'b0;
    ph_we_o = 1'b0;
    if (frm_start) begin
      idx_d = '0;
      if (frm_byte == SCOPED_CODE)     st_d = PS_COUNT;
      else if (frm_byte == PAGE_CODE)  st_d = PS_PAGE;
      else if (frm_byte == PHASE_CODE) st_d = PS_PHASE;
      else                             st_d = PS_SKIP;
    end else if (frm_stop) begin
      st_d = PS_IDLE;
    end else if (frm_valid) begin
      case (st_q)
        PS_COUNT: begin
          if (frm_byte == EXP_CNT) begin
            st_d = PS_BODY;
          end else begin
            cerr_d = 1'b1;
            st_d   = PS_SKIP;
          end
        end
        PS_BODY: begin
          byte_we = 1'b1;
          if (idx_q == LAST_IDX) begin
            done_d = 1'b1;
            st_d   = PS_SKIP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        PS_PAGE: begin
          pg_we_o = 1'b1;
          st_d    = PS_SKIP;
        end
        PS_PHASE: begin
          ph_we_o = 1'b1;
          st_d    = PS_SKIP;
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      cerr_q <= cerr_d;
    end
  end

  // Payload byte slots, one enable per slot
  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q <= 8'h00;
      else if (byte_we && (idx_q == IDX_W'(g)))     slot_q <= frm_byte;
    end
    assign frame_o[8*g +: 8] = slot_q;
  end

  assign done_o    = done_q;
  assign cnt_err_o = cerr_q;

endmodule

// File: rtl/pmb_sw_selchk.sv
module pmb_sw_selchk #(
  parameter int unsigned POS_W  = 3,
  parameter int unsigned MASK_W = 8
) (
  input  logic [7:0]        page_i,
  input  logic [7:0]        phase_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              ok_o,
  output logic [MASK_W-1:0] mask_o
);

  logic page_ok;
  logic phase_all;
  logic phase_own;

  assign page_ok   = (page_i == 8'h00) || (page_i == 8'hFF);
  assign phase_all = (phase_i == 8'hFF);
  assign phase_own = (phase_i == 8'(pos_i));
  assign ok_o      = page_ok && (phase_all || phase_own);

  for (genvar g = 0; g < MASK_W; g++) begin : g_mask
    assign mask_o[g] = phase_all || (pos_i == POS_W'(g));
  end

endmodule

// File: rtl/pmb_sw_selregs.sv
module pmb_sw_selregs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_we,
  input  logic       ph_we,
  input  logic [7:0] wdata,
  output logic [7:0] page_o,
  output logic [7:0] phase_o
);

  logic [7:0] page_q, page_d;
  logic [7:0] phase_q, phase_d;

  always_comb begin
    page_d  = pg_we ? wdata : page_q;
    phase_d = ph_we ? wdata : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= 8'h00;
      phase_q <= 8'h00;
    end else begin
      page_q  <= page_d;
      phase_q <= phase_d;
    end
  end

  assign page_o  = page_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/pmb_scoped_write.sv
module pmb_scoped_write
  import pmb_sw_pkg::*;
#(
  parameter logic [7:0]  SCOPED_CODE = 8'h09,
  parameter logic [7:0]  PAGE_CODE   = 8'h00,
  parameter logic [7:0]  PHASE_CODE  = 8'h04,
  parameter int unsigned NEST_BYTES  = 2,
  parameter int unsigned POS_W       = 3,
  localparam int unsigned FRAME_LEN  = NEST_BYTES + 3,
  localparam int unsigned MASK_W     = 1 << POS_W,
  localparam int unsigned DATA_W     = 8 * NEST_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              frm_valid,
  input  logic [7:0]        frm_byte,
  input  logic              frm_stop,
  input  logic [POS_W-1:0]  stack_pos,
  input  logic              clr_status,
  output logic              wr_stb,
  output logic [7:0]        wr_cmd,
  output logic [MASK_W-1:0] wr_phase_mask,
  output logic [DATA_W-1:0] wr_data,
  output logic              inv_cmd,
  output logic              alert_n,
  output logic [7:0]        sel_page,
  output logic [7:0]        sel_phase
);

  logic                   sync_rst_n;
  logic                   done;
  logic                   cnt_err;
  logic                   pg_we;
  logic                   ph_we;
  logic [8*FRAME_LEN-1:0] frame;
  logic                   sel_ok;
  logic                   err_set;
  logic                   inv_q, inv_d;

  pmb_sw_rst_sync rst_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (sync_rst_n)
  );

  pmb_sw_parse #(
    .SCOPED_CODE (SCOPED_CODE),
    .PAGE_CODE   (PAGE_CODE),
    .PHASE_CODE  (PHASE_CODE),
    .FRAME_LEN   (FRAME_LEN)
  ) parse_i (
    .clk       (clk),
    .rst_n     (sync_rst_n),
    .frm_start (frm_start),
    .frm_valid (frm_valid),
    .frm_byte  (frm_byte),
    .frm_stop  (frm_stop),
    .done_o    (done),
    .cnt_err_o (cnt_err),
    .pg_we_o   (pg_we),
    .ph_we_o   (ph_we),
    .frame_o   (frame)
  );

  pmb_sw_selchk #(
    .POS_W  (POS_W),
    .MASK_W (MASK_W)
  ) chk_sel_i (
    .page_i  (frame[8*POS_PAGE +: 8]),
    .phase_i (frame[8*POS_PHASE +: 8]),
    .pos_i   (stack_pos),
    .ok_o    (sel_ok),
    .mask_o  (wr_phase_mask)
  );

  pmb_sw_selregs regs_i (
    .clk     (clk),
    .rst_n   (sync_rst_n),
    .pg_we   (pg_we),
    .ph_we   (ph_we),
    .wdata   (frm_byte),
    .page_o  (sel_page),
    .phase_o (sel_phase)
  );

  // Dispatch and sticky error flag
  assign err_set = (done && !sel_ok) || cnt_err;

  always_comb begin
    inv_d = inv_q;
    if (err_set)         inv_d = 1'b1;
    else if (clr_status) inv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge sync_rst_n) begin
    if (!sync_rst_n) inv_q <= 1'b0;
    else             inv_q <= inv_d;
  end

  assign wr_stb  = done && sel_ok;
  assign wr_cmd  = frame[8*POS_CMD +: 8];
  assign wr_data = frame[8*POS_DATA +: DATA_W];
  assign inv_cmd = inv_q;
  assign alert_n = !inv_q;

endmodule

// File: rtl/pmb_sw_chk.sv
module pmb_sw_chk #(
  parameter int unsigned POS_W  = 3,
  parameter int unsigned MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [MASK_W-1:0] wr_phase_mask,
  input logic [POS_W-1:0]  stack_pos,
  input logic              inv_cmd,
  input logic              clr_status,
  input logic [7:0]        sel_page,
  input logic [7:0]        sel_phase,
  input logic              pg_we,
  input logic              ph_we
);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r3_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (($countones(wr_phase_mask) == 1) || (&wr_phase_mask)));

  a_r3_mask_own_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !(&wr_phase_mask)) |-> wr_phase_mask[stack_pos]);

  a_r4_no_stb_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_cmd) |-> !$past(wr_stb));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_cmd && !clr_status) |=> inv_cmd);

  a_r7_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_we |=> $stable(sel_page));

  a_r7_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_we |=> $stable(sel_phase));

endmodule

bind pmb_scoped_write pmb_sw_chk #(
  .POS_W  (POS_W),
  .MASK_W (MASK_W)
) sva_i (
  .clk           (clk),
  .rst_n         (sync_rst_n),
  .wr_stb        (wr_stb),
  .wr_phase_mask (wr_phase_mask),
  .stack_pos     (stack_pos),
  .inv_cmd       (inv_cmd),
  .clr_status    (clr_status),
  .sel_page      (sel_page),
  .sel_phase     (sel_phase),
  .pg_we         (pg_we),
  .ph_we         (ph_we)
);

// File: tb/pmb_scoped_write_tb_top.sv
module pmb_scoped_write_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_start, frm_valid, frm_stop, clr_status;
  logic [7:0]  frm_byte;
  logic [2:0]  stack_pos;
  logic        wr_stb;
  logic [7:0]  wr_cmd;
  logic [7:0]  wr_phase_mask;
  logic [15:0] wr_data;
  logic        inv_cmd, alert_n;
  logic [7:0]  sel_page, sel_phase;

  int n_chk = 0;
  int n_bad = 0;
  int stb_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pmb_scoped_write dut_i (
    .clk (clk), .rst_n (rst_n),
    .frm_start (frm_start), .frm_valid (frm_valid), .frm_byte (frm_byte),
    .frm_stop (frm_stop), .stack_pos (stack_pos), .clr_status (clr_status),
    .wr_stb (wr_stb), .wr_cmd (wr_cmd), .wr_phase_mask (wr_phase_mask),
    .wr_data (wr_data), .inv_cmd (inv_cmd), .alert_n (alert_n),
    .sel_page (sel_page), .sel_phase (sel_phase)
  );

  always @(posedge clk) if (rst_n && wr_stb) stb_cnt++;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_start(input logic [7:0] code);
    frm_start = 1'b1; frm_byte = code;
    @(negedge clk);
    frm_start = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    frm_valid = 1'b1; frm_byte = b;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic put_stop();
    frm_stop = 1'b1;
    @(negedge clk);
    frm_stop = 1'b0;
  endtask

  // Sends a scoped frame without the stop; returns right after the last byte
  task automatic send_scoped(input logic [7:0] cnt, input logic [7:0] pg,
                             input logic [7:0] ph, input logic [7:0] cmd,
                             input logic [7:0] d0, input logic [7:0] d1);
    put_start(8'h09);
    put_byte(cnt);
    put_byte(pg);
    put_byte(ph);
    put_byte(cmd);
    put_byte(d0);
    put_byte(d1);
  endtask

  task automatic clear_flag();
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "wr_stb", 32'(wr_stb), 32'd0);
    chk("R10", "inv_cmd", 32'(inv_cmd), 32'd0);
    chk("R10", "alert_n", 32'(alert_n), 32'd1);
    chk("R10", "sel_page", 32'(sel_page), 32'h00);
    chk("R10", "sel_phase", 32'(sel_phase), 32'h00);
  endtask

  task automatic t_persist();
    put_start(8'h00);
    put_byte(8'h03);
    chk("R7", "sel_page load", 32'(sel_page), 32'h03);
    put_stop();
    put_start(8'h04);
    put_byte(8'h02);
    chk("R7", "sel_phase load", 32'(sel_phase), 32'h02);
    put_stop();
  endtask

  task automatic t_all_phases();
    int base = stb_cnt;
    send_scoped(8'd5, 8'h00, 8'hFF, 8'h21, 8'h34, 8'h12);
    chk("R1", "wr_stb", 32'(wr_stb), 32'd1);
    chk("R1", "wr_cmd", 32'(wr_cmd), 32'h21);
    chk("R1", "wr_data", 32'(wr_data), 32'h1234);
    chk("R3", "mask all", 32'(wr_phase_mask), 32'hFF);
    tick(1);
    chk("R1", "wr_stb one cycle", 32'(wr_stb), 32'd0);
    put_stop();
    tick(1);
    chk("R1", "strobe count", 32'(stb_cnt - base), 32'd1);
    chk("R7", "sel_page kept", 32'(sel_page), 32'h03);
    chk("R7", "sel_phase kept", 32'(sel_phase), 32'h02);
    chk("R1", "no flag", 32'(inv_cmd), 32'd0);
  endtask

  task automatic t_page_ff_own();
    send_scoped(8'd5, 8'hFF, 8'h05, 8'h21, 8'h34, 8'h12);
    chk("R2", "wr_stb page FF", 32'(wr_stb), 32'd1);
    chk("R2", "wr_cmd page FF", 32'(wr_cmd), 32'h21);
    chk("R2", "wr_data page FF", 32'(wr_data), 32'h1234);
    chk("R3", "mask own bit", 32'(wr_phase_mask), 32'h20);
    put_stop();
  endtask

  task automatic t_bad_page();
    int base = stb_cnt;
    send_scoped(8'd5, 8'h01, 8'hFF, 8'h3B, 8'hAA, 8'h55);
    chk("R4", "no strobe bad page", 32'(wr_stb), 32'd0);
    tick(1);
    chk("R4", "inv set", 32'(inv_cmd), 32'd1);
    chk("R4", "alert low", 32'(alert_n), 32'd0);
    put_stop();
    tick(3);
    chk("R6", "flag sticky", 32'(inv_cmd), 32'd1);
    chk("R4", "strobe count", 32'(stb_cnt - base), 32'd0);
    clear_flag();
    chk("R6", "cleared", 32'(inv_cmd), 32'd0);
    chk("R6", "alert released", 32'(alert_n), 32'd1);
  endtask

  task automatic t_bad_phase_vs_clear();
    send_scoped(8'd5, 8'h00, 8'h03, 8'h3B, 8'hAA, 8'h55);
    chk("R4", "no strobe bad phase", 32'(wr_stb), 32'd0);
    clear_flag();   // clear in the same cycle as the error: set wins
    chk("R6", "set beats clear", 32'(inv_cmd), 32'd1);
    put_stop();
    clear_flag();
    chk("R6", "cleared again", 32'(inv_cmd), 32'd0);
  endtask

  task automatic t_bad_count();
    int base = stb_cnt;
    put_start(8'h09);
    put_byte(8'd4);
    tick(1);
    chk("R5", "inv on count", 32'(inv_cmd), 32'd1);
    put_byte(8'h00); put_byte(8'hFF); put_byte(8'h21); put_byte(8'h34);
    put_byte(8'h12);
    put_stop();
    tick(1);
    chk("R5", "rest ignored", 32'(stb_cnt - base), 32'd0);
    clear_flag();
  endtask

  task automatic t_other_cmd();
    int base = stb_cnt;
    put_start(8'h21);
    put_byte(8'h05); put_byte(8'h00); put_byte(8'hFF); put_byte(8'h21);
    put_byte(8'h34); put_byte(8'h12);
    put_stop();
    tick(2);
    chk("R8", "no strobe", 32'(stb_cnt - base), 32'd0);
    chk("R8", "no flag", 32'(inv_cmd), 32'd0);
    chk("R8", "sel_page kept", 32'(sel_page), 32'h03);
    chk("R8", "sel_phase kept", 32'(sel_phase), 32'h02);
  endtask

  task automatic t_abort();
    int base = stb_cnt;
    put_start(8'h09);
    put_byte(8'd5); put_byte(8'h00); put_byte(8'hFF);
    put_stop();
    tick(3);
    chk("R9", "no strobe", 32'(stb_cnt - base), 32'd0);
    chk("R9", "no flag", 32'(inv_cmd), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; frm_start = 1'b0; frm_valid = 1'b0; frm_stop = 1'b0;
    frm_byte = 8'h00; clr_status = 1'b0; stack_pos = 3'd5;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_persist();
    t_all_phases();
    t_page_ff_own();
    t_bad_page();
    t_bad_phase_vs_clear();
    t_bad_count();
    t_other_cmd();
    t_abort();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule